// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the architectural state update that happens when a hart takes a trap. On a trap event it receives the event's kind (interrupt or synchronous exception), its cause number and an optional faulting address, along with the current privilege, PC and status word, both delegation masks and both trap-vector bases. It decides whether the trap is handled at supervisor or machine level. It then writes the target level's cause, exception-PC and trap-value registers, the updated status word, the new privilege and the fetch address of the handler, all in one clock edge.

The surrounding pipeline raises `ev_valid` for one cycle per trap. The registered outputs become the architectural state seen from the next cycle onward. When no trap is presented, every output register keeps its value.

Top module: `trap_entry_unit`

## Requirements
- R1: The interrupt delegation mask (`irq_deleg`) is consulted when `ev_async` is 1. The exception delegation mask (`exc_deleg`) is consulted when `ev_async` is 0.
- R2: The trap is taken at supervisor level (`new_priv` = 1) only when all three of these hold: `cur_priv` is 0 (user) or 1 (supervisor), the effective cause is below XLEN, and the selected mask has its bit at the cause index set. In every other case the trap is taken at machine level (`new_priv` = 3).
- R3: On supervisor entry, status bit 5 receives the old bit 1, bit 8 receives bit 0 of the old privilege, and bit 1 is cleared. Every other status bit is copied from `cur_status`.
- R4: On machine entry, status bit 7 receives the old bit 3, bits 12:11 receive the old privilege, and bit 3 is cleared. Every other status bit is copied from `cur_status`.
- R5: The target level's cause register holds the effective cause, zero-extended, with bit XLEN-1 set for an interrupt and clear for an exception.
- R6: The target level's exception-PC register takes `cur_pc`. The cause, exception-PC and trap-value registers of the other level keep their values.
- R7: The trap value is `ev_addr` only for synchronous exceptions whose cause is one of 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception, and for every interrupt, the trap value is 0.
- R8: `new_pc` is the target level's vector base with its two low bits cleared.
- R9: When the low two bits of the target vector base are 01 and the event is an interrupt, 4 × cause is added to `new_pc`. Exceptions, and interrupts taken with mode 00, 10 or 11, add nothing.
- R10: An exception with cause 8 (user call) is renumbered before delegation: it becomes 9 when `cur_priv` is 1 and 11 when `cur_priv` is 3. It stays 8 when `cur_priv` is 0.
- R11: After the trap, `new_priv` equals the target level.
- R12: In a cycle without `ev_valid`, every output register holds its value regardless of the other inputs.
- R13: Reset sets `new_priv` to 3 and `new_pc` to RESET_PC (default 0), and clears the status word and all cause, exception-PC and trap-value registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | A trap is taken at this edge |
| ev_async | input | 1 | 1 = interrupt, 0 = exception |
| ev_code | input | CAUSE_W | Raw cause number |
| ev_addr | input | XLEN | Faulting address for address-carrying exceptions |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_status | input | XLEN | Current status word |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| m_vec_base | input | XLEN | Machine trap-vector base and mode |
| s_vec_base | input | XLEN | Supervisor trap-vector base and mode |
| new_priv | output | 2 | Privilege after the trap |
| new_status | output | XLEN | Status word after the trap |
| m_cause | output | XLEN | Machine cause register |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine trap value |
| s_cause | output | XLEN | Supervisor cause register |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor trap value |
| new_pc | output | XLEN | Handler fetch address |

## Verification
Traps are raised from each privilege with the delegation bit set in one mask, in the other mask, in both, and in neither. This separates a wrong mask choice from a wrong privilege gate. Interrupts and exceptions share cause 5, which shows whether the trap value and vector offset depend on the event kind rather than the number alone. User calls from all three privileges, combined with masks that delegate only the renumbered code, reveal whether renumbering precedes the delegation lookup. A cause above XLEN with a mask of all ones, together with vector modes 00, 01 and 11, covers the range gate and the vector offset rule.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_SUPV = 2'd1,
      LVL_RSVD = 2'd2,
      LVL_MACH = 2'd3
   } lvl_e;

   // status word bit positions
   localparam int unsigned ST_S_IE   = 1;
   localparam int unsigned ST_M_IE   = 3;
   localparam int unsigned ST_S_PIE  = 5;
   localparam int unsigned ST_M_PIE  = 7;
   localparam int unsigned ST_S_PP   = 8;
   localparam int unsigned ST_M_PP   = 11;

   // call causes
   localparam int unsigned CALL_FROM_U = 8;
   localparam int unsigned CALL_FROM_S = 9;
   localparam int unsigned CALL_FROM_M = 11;

   // exception codes that carry a faulting address (0,1,4,5,6,7,12,13,15)
   localparam logic [15:0] ADDR_CODES = 16'hB0F3;
endpackage

// File: rtl/trap_route.sv
module trap_route
   import trap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 6
) (
   input  logic               ev_async,
   input  logic [CAUSE_W-1:0] ev_code,
   input  logic [1:0]         cur_priv,
   input  logic [XLEN-1:0]    exc_deleg,
   input  logic [XLEN-1:0]    irq_deleg,
   output logic [CAUSE_W-1:0] eff_code,
   output logic               to_supv
);
   logic [XLEN-1:0] mask_sel;
   logic [XLEN-1:0] mask_shift;
   logic            in_range;
   logic            low_priv;

   always_comb begin
      eff_code = ev_code;
      if (!ev_async && ev_code == CAUSE_W'(CALL_FROM_U)) begin
         unique case (lvl_e'(cur_priv))
            LVL_MACH: eff_code = CAUSE_W'(CALL_FROM_M);
            LVL_SUPV: eff_code = CAUSE_W'(CALL_FROM_S);
            default:  eff_code = ev_code;
         endcase
      end
   end

   always_comb begin
      mask_sel   = ev_async ? irq_deleg : exc_deleg;
      mask_shift = mask_sel >> eff_code;
      in_range   = (int'({1'b0, eff_code}) < XLEN);
      low_priv   = (cur_priv == LVL_USER) || (cur_priv == LVL_SUPV);
      to_supv    = low_priv && in_range && mask_shift[0];
   end
endmodule

// File: rtl/trap_tval_sel.sv
module trap_tval_sel
   import trap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 6
) (
   input  logic               ev_async,
   input  logic [CAUSE_W-1:0] eff_code,
   input  logic [XLEN-1:0]    ev_addr,
   output logic [XLEN-1:0]    tval
);
   logic small_code;
   logic keeps_addr;

   generate
      if (CAUSE_W > 4) begin : g_wide
         assign small_code = (eff_code[CAUSE_W-1:4] == '0);
      end else begin : g_narrow
         assign small_code = 1'b1;
      end
   endgenerate

   always_comb begin
      keeps_addr = !ev_async && small_code && ADDR_CODES[eff_code[3:0]];
      tval       = keeps_addr ? ev_addr : '0;
   end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
   parameter int XLEN     = 32,
   parameter int CAUSE_W  = 6,
   parameter bit VECTORED = 1'b1
) (
   input  logic [XLEN-1:0]    vec_base,
   input  logic               ev_async,
   input  logic [CAUSE_W-1:0] eff_code,
   output logic [XLEN-1:0]    target
);
   logic [XLEN-1:0] offset;

   generate
      if (VECTORED) begin : g_vec
         always_comb begin
            offset = '0;
            if (ev_async && vec_base[1:0] == 2'b01)
               offset = XLEN'(eff_code) << 2;
         end
      end else begin : g_direct
         assign offset = '0;
      end
   endgenerate

   assign target = {vec_base[XLEN-1:2], 2'b00} + offset;
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          CAUSE_W  = 6,
   parameter bit          VECTORED = 1'b1,
   parameter logic [63:0] RESET_PC = 64'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_valid,
   input  logic               ev_async,
   input  logic [CAUSE_W-1:0] ev_code,
   input  logic [XLEN-1:0]    ev_addr,
   input  logic [1:0]         cur_priv,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [XLEN-1:0]    cur_status,
   input  logic [XLEN-1:0]    exc_deleg,
   input  logic [XLEN-1:0]    irq_deleg,
   input  logic [XLEN-1:0]    m_vec_base,
   input  logic [XLEN-1:0]    s_vec_base,
   output logic [1:0]         new_priv,
   output logic [XLEN-1:0]    new_status,
   output logic [XLEN-1:0]    m_cause,
   output logic [XLEN-1:0]    m_epc,
   output logic [XLEN-1:0]    m_tval,
   output logic [XLEN-1:0]    s_cause,
   output logic [XLEN-1:0]    s_epc,
   output logic [XLEN-1:0]    s_tval,
   output logic [XLEN-1:0]    new_pc
);
   localparam int MAX_CODE = (1 << CAUSE_W) - 1;

   initial begin
      assert (XLEN == 32 || XLEN == 64)
         else $error("trap_entry_unit: XLEN must be 32 or 64");
      assert (CAUSE_W >= 4 && CAUSE_W < XLEN)
         else $error("trap_entry_unit: CAUSE_W out of range");
      assert (MAX_CODE >= int'(CALL_FROM_M))
         else $error("trap_entry_unit: CAUSE_W too narrow for call causes");
   end

   logic [CAUSE_W-1:0] eff_code;
   logic               to_supv;
   logic [XLEN-1:0]    tval_d;
   logic [XLEN-1:0]    vec_sel;
   logic [XLEN-1:0]    pc_d;
   logic [XLEN-1:0]    cause_d;
   logic [XLEN-1:0]    status_d;

   trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
      .ev_async  (ev_async),
      .ev_code   (ev_code),
      .cur_priv  (cur_priv),
      .exc_deleg (exc_deleg),
      .irq_deleg (irq_deleg),
      .eff_code  (eff_code),
      .to_supv   (to_supv)
   );

   trap_tval_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tval (
      .ev_async (ev_async),
      .eff_code (eff_code),
      .ev_addr  (ev_addr),
      .tval     (tval_d)
   );

   assign vec_sel = to_supv ? s_vec_base : m_vec_base;

   trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTORED(VECTORED)) u_vec (
      .vec_base (vec_sel),
      .ev_async (ev_async),
      .eff_code (eff_code),
      .target   (pc_d)
   );

   always_comb begin
      cause_d            = XLEN'(eff_code);
      cause_d[XLEN-1]    = ev_async;
      status_d           = cur_status;
      if (to_supv) begin
         status_d[ST_S_PIE] = cur_status[ST_S_IE];
         status_d[ST_S_PP]  = cur_priv[0];
         status_d[ST_S_IE]  = 1'b0;
      end else begin
         status_d[ST_M_PIE]           = cur_status[ST_M_IE];
         status_d[ST_M_PP+1:ST_M_PP]  = cur_priv;
         status_d[ST_M_IE]            = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         new_priv   <= LVL_MACH;
         new_status <= '0;
         m_cause    <= '0;
         m_epc      <= '0;
         m_tval     <= '0;
         s_cause    <= '0;
         s_epc      <= '0;
         s_tval     <= '0;
         new_pc     <= RESET_PC[XLEN-1:0];
      end else if (ev_valid) begin
         new_status <= status_d;
         new_pc     <= pc_d;
         if (to_supv) begin
            new_priv <= LVL_SUPV;
            s_cause  <= cause_d;
            s_epc    <= cur_pc;
            s_tval   <= tval_d;
         end else begin
            new_priv <= LVL_MACH;
            m_cause  <= cause_d;
            m_epc    <= cur_pc;
            m_tval   <= tval_d;
         end
      end
   end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ev_valid,
   input logic               ev_async,
   input logic [1:0]         cur_priv,
   input logic [XLEN-1:0]    cur_pc,
   input logic [XLEN-1:0]    cur_status,
   input logic [1:0]         new_priv,
   input logic [XLEN-1:0]    new_status,
   input logic [XLEN-1:0]    m_cause,
   input logic [XLEN-1:0]    m_epc,
   input logic [XLEN-1:0]    s_cause,
   input logic [XLEN-1:0]    s_epc,
   input logic [XLEN-1:0]    new_pc
);
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> $stable(new_pc) && $stable(new_priv) && $stable(new_status)
                    && $stable(m_epc) && $stable(s_epc));

   p_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> (new_priv == 2'd3 || new_priv == 2'd1));

   p_mach_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && cur_priv == 2'd3 |=> new_priv == 2'd3);

   p_supv_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> (new_priv != 2'd1) ||
         (!new_status[1] && new_status[5] == $past(cur_status[1]) &&
          new_status[8] == $past(cur_priv[0]) && s_epc == $past(cur_pc)));

   p_mach_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> (new_priv != 2'd3) ||
         (!new_status[3] && new_status[7] == $past(cur_status[3]) &&
          new_status[12:11] == $past(cur_priv) && m_epc == $past(cur_pc)));

   p_irq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && ev_async |=> (new_priv == 2'd3) ? m_cause[XLEN-1] : s_cause[XLEN-1]);

   p_exc_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && !ev_async |=> new_pc[1:0] == 2'b00);
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_valid   (ev_valid),
   .ev_async   (ev_async),
   .cur_priv   (cur_priv),
   .cur_pc     (cur_pc),
   .cur_status (cur_status),
   .new_priv   (new_priv),
   .new_status (new_status),
   .m_cause    (m_cause),
   .m_epc      (m_epc),
   .s_cause    (s_cause),
   .s_epc      (s_epc),
   .new_pc     (new_pc)
);

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
   localparam int XLEN = 32;
   localparam int CW   = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ev_valid = 1'b0;
   logic            ev_async = 1'b0;
   logic [CW-1:0]   ev_code = '0;
   logic [XLEN-1:0] ev_addr = '0;
   logic [1:0]      cur_priv = 2'd3;
   logic [XLEN-1:0] cur_pc = '0;
   logic [XLEN-1:0] cur_status = '0;
   logic [XLEN-1:0] exc_deleg = '0;
   logic [XLEN-1:0] irq_deleg = '0;
   logic [XLEN-1:0] m_vec_base = 32'h0000_1000;
   logic [XLEN-1:0] s_vec_base = 32'h0000_2001;
   logic [1:0]      new_priv;
   logic [XLEN-1:0] new_status, m_cause, m_epc, m_tval;
   logic [XLEN-1:0] s_cause, s_epc, s_tval, new_pc;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_async(ev_async),
      .ev_code(ev_code), .ev_addr(ev_addr), .cur_priv(cur_priv), .cur_pc(cur_pc),
      .cur_status(cur_status), .exc_deleg(exc_deleg), .irq_deleg(irq_deleg),
      .m_vec_base(m_vec_base), .s_vec_base(s_vec_base), .new_priv(new_priv),
      .new_status(new_status), .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval),
      .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval), .new_pc(new_pc)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive one trap at a falling edge; results are sampled at the next falling edge
   task automatic fire(input logic as, input logic [CW-1:0] code, input logic [XLEN-1:0] addr,
                       input logic [1:0] pv, input logic [XLEN-1:0] pc,
                       input logic [XLEN-1:0] st, input logic [XLEN-1:0] ed,
                       input logic [XLEN-1:0] id);
      @(negedge clk);
      ev_async = as; ev_code = code; ev_addr = addr; cur_priv = pv;
      cur_pc = pc; cur_status = st; exc_deleg = ed; irq_deleg = id;
      ev_valid = 1'b1;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R13 priv", 64'(new_priv), 64'd3);
      chk("R13 pc", 64'(new_pc), 64'h0);
      chk("R13 status", 64'(new_status), 64'h0);
      chk("R13 mcause", 64'(m_cause), 64'h0);
      chk("R13 scause", 64'(s_cause), 64'h0);
   endtask

   task automatic t_supv_fault();
      fire(1'b0, 6'd13, 32'hDEAD_0000, 2'd0, 32'h400, 32'h2, 32'h1 << 13, 32'h0);
      chk("R2 supv target", 64'(new_priv), 64'd1);
      chk("R11 priv", 64'(new_priv), 64'd1);
      chk("R5 scause", 64'(s_cause), 64'd13);
      chk("R6 sepc", 64'(s_epc), 64'h400);
      chk("R6 mcause held", 64'(m_cause), 64'h0);
      chk("R7 stval", 64'(s_tval), 64'hDEAD_0000);
      chk("R3 status", 64'(new_status), 64'h20);
      chk("R9 exc not vectored", 64'(new_pc), 64'h2000);
   endtask

   task automatic t_mach_fault();
      fire(1'b0, 6'd13, 32'hBEEF_0000, 2'd3, 32'h800, 32'h8, 32'h1 << 13, 32'h0);
      chk("R2 from M stays M", 64'(new_priv), 64'd3);
      chk("R4 status", 64'(new_status), 64'h1880);
      chk("R5 mcause", 64'(m_cause), 64'd13);
      chk("R6 mepc", 64'(m_epc), 64'h800);
      chk("R7 mtval", 64'(m_tval), 64'hBEEF_0000);
      chk("R8 pc", 64'(new_pc), 64'h1000);
      chk("R6 sepc held", 64'(s_epc), 64'h400);
   endtask

   task automatic t_supv_irq();
      fire(1'b1, 6'd5, 32'h1234_5678, 2'd1, 32'h900, 32'h2, 32'h0, 32'h1 << 5);
      chk("R1 irq mask used", 64'(new_priv), 64'd1);
      chk("R5 irq flag", 64'(s_cause), 64'h8000_0005);
      chk("R7 irq tval zero", 64'(s_tval), 64'h0);
      chk("R9 vectored", 64'(new_pc), 64'h2014);
      chk("R3 spp", 64'(new_status), 64'h120);
   endtask

   task automatic t_wrong_mask();
      fire(1'b1, 6'd5, 32'h0, 2'd0, 32'hA00, 32'h8, 32'h1 << 5, 32'h0);
      chk("R1 exc mask ignored for irq", 64'(new_priv), 64'd3);
      chk("R5 mcause", 64'(m_cause), 64'h8000_0005);
      chk("R4 status", 64'(new_status), 64'h80);
      chk("R8 direct", 64'(new_pc), 64'h1000);
   endtask

   task automatic t_calls();
      fire(1'b0, 6'd8, 32'h1234, 2'd1, 32'hB00, 32'h0, 32'h1 << 9, 32'h0);
      chk("R10 call from S", 64'(s_cause), 64'd9);
      chk("R10 S priv", 64'(new_priv), 64'd1);
      chk("R7 call tval zero", 64'(s_tval), 64'h0);
      chk("R3 spp set", 64'(new_status), 64'h100);
      fire(1'b0, 6'd8, 32'h0, 2'd3, 32'hC00, 32'h0, '1, 32'h0);
      chk("R10 call from M", 64'(m_cause), 64'd11);
      chk("R4 mpp", 64'(new_status), 64'h1800);
      fire(1'b0, 6'd8, 32'h0, 2'd0, 32'hD00, 32'h0, 32'h1 << 8, 32'h0);
      chk("R10 call from U", 64'(s_cause), 64'd8);
      chk("R10 U priv", 64'(new_priv), 64'd1);
   endtask

   task automatic t_wide_code();
      m_vec_base = 32'h0000_1001;
      fire(1'b1, 6'd40, 32'h0, 2'd0, 32'hE00, 32'h0, 32'h0, '1);
      chk("R2 code above XLEN", 64'(new_priv), 64'd3);
      chk("R5 wide cause", 64'(m_cause), 64'h8000_0028);
      chk("R9 vectored offset", 64'(new_pc), 64'h10A0);
   endtask

   task automatic t_hold();
      logic [XLEN-1:0] pc0, ep0;
      pc0 = new_pc; ep0 = m_epc;
      @(negedge clk);
      cur_pc = 32'hFFFF_FFF0; ev_code = 6'd2; cur_priv = 2'd0; cur_status = '1;
      repeat (3) @(negedge clk);
      chk("R12 pc held", 64'(new_pc), 64'(pc0));
      chk("R12 mepc held", 64'(m_epc), 64'(ep0));
      chk("R12 priv held", 64'(new_priv), 64'd3);
   endtask

   task automatic t_mode3_and_tval();
      m_vec_base = 32'h0000_3003;
      fire(1'b1, 6'd7, 32'h77, 2'd3, 32'hF00, 32'h0, 32'h0, 32'h0);
      chk("R9 mode 11 no offset", 64'(new_pc), 64'h3000);
      chk("R7 irq tval", 64'(m_tval), 64'h0);
      m_vec_base = 32'h0000_1001;
      fire(1'b0, 6'd0, 32'h55, 2'd3, 32'hF04, 32'h0, 32'h0, 32'h0);
      chk("R7 misaligned fetch tval", 64'(m_tval), 64'h55);
      chk("R9 exc ignores mode 01", 64'(new_pc), 64'h1000);
      fire(1'b0, 6'd2, 32'h66, 2'd3, 32'hF08, 32'h0, 32'h0, 32'h0);
      chk("R7 illegal tval zero", 64'(m_tval), 64'h0);
      fire(1'b0, 6'd15, 32'h99, 2'd0, 32'hF0C, 32'h0, 32'h0, 32'h0);
      chk("R7 store fault tval", 64'(m_tval), 64'h99);
      fire(1'b0, 6'd14, 32'hAA, 2'd0, 32'hF10, 32'h0, 32'h0, 32'h0);
      chk("R7 code 14 tval zero", 64'(m_tval), 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_supv_fault();
      t_mach_fault();
      t_supv_irq();
      t_wrong_mask();
      t_calls();
      t_wide_code();
      t_hold();
      t_mode3_and_tval();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule